// File: doc/BRIEF.md
# SAR ADC Conversion and Capture Controller

This block runs a parallel-output successive-approximation converter and hands its results to a 16-bit host bus. It produces the convert-start pulse stream from the master clock at a fixed period set by a parameter. When selected, it instead forwards an externally supplied convert-start unchanged. The converter does all of its own bit-decision timing. The controller only starts conversions, follows the converter's busy flag, and picks the cycle in which the converter's data bus is latched.

The converter's chip-select and read lines are held active permanently, so its data bus never floats and is refreshed after every conversion. A read-timing input picks the latch point. One setting latches when busy falls, which captures the new result. The other latches when busy rises, which captures the previous result while the next conversion is running. Conversion runs either without stopping or in burst form, where convert-start stays low until the host asks for one conversion or holds a run request.

Each latched result is kept at full width on a wide output. It is also formatted onto the 16-bit host word in one of three ways: plain, byte-exchanged for an 8-bit path, or split across two consecutive words for results wider than 16 bits. A pair of complementary update strobes marks each change of the host word.

Top module: `sar_capture_top`

## Requirements
- R1: With the external select low and conversions enabled, convert-start is high for exactly PULSE_HIGH consecutive cycles (at least 2). Successive pulses begin CONV_PERIOD cycles apart while busy is low at each start point.
- R2: A new internal convert-start pulse never begins in a cycle where busy is sampled high. If the period has expired while busy is high, the pulse begins in the first cycle in which busy is sampled low.
- R3: With the external select high, convert-start equals the external convert-start input in the same cycle, and the internal generator is held in its idle state.
- R4: In burst mode, no internal pulse is issued unless the run request is high or a single-conversion request is pending. A single-conversion request yields exactly one pulse.
- R5: The converter chip-select and read outputs (active low) are 0 at all times.
- R6: With read timing 0, the converter data is latched in the cycle in which busy is first sampled low after being high. With read timing 1, it is latched in the cycle in which busy is first sampled high. The latched value appears on the full-width result output, with the valid flag set, one cycle later, and the valid flag stays set until reset.
- R7: The host word is formatted from the latched data according to the host mode. Mode 0 is the 16 most-significant bits. Mode 1 is those 16 bits with their two bytes exchanged. Mode 2 first presents the top 16 bits with the word index 0; a next-word request then presents the remaining low bits in bits [15:14] with zeros below, and sets the word index to 1. If a latch and a next-word request fall in the same cycle, the latch wins.
- R8: The update strobe (active low) is 0, and its complement is 1, for exactly the cycles in which the host word or word index has just taken a new value. Otherwise the update strobe is 1.
- R9: A synchronous reset drives convert-start low when the internal source is selected, and clears the latched result, the valid flag, the host word and the word index. It also sets the update strobe to 1.
- R10: A next-word request has no effect on the host word or word index in modes 0, 1 and 3, when the word index is already 1, or before the first result has been latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| extSel | input | 1 | 1 = forward external convert-start |
| extConvStart | input | 1 | External convert-start |
| burstMode | input | 1 | 1 = burst conversion, 0 = continuous |
| captureRun | input | 1 | Burst: keep converting while high |
| captureSingle | input | 1 | Burst: request one conversion (pulse) |
| readDuringConv | input | 1 | 1 = latch on busy rise, 0 = latch on busy fall |
| hostMode | input | 2 | 0 plain, 1 byte-exchanged, 2 two-word, 3 plain |
| hostNext | input | 1 | Request the second word of a two-word result |
| adcBusy | input | 1 | Converter busy flag |
| adcData | input | RES_BITS | Converter parallel data |
| convStart | output | 1 | Convert-start to the converter |
| adcCsN | output | 1 | Converter chip select, active low |
| adcRdN | output | 1 | Converter read, active low |
| fullResult | output | RES_BITS | Latched full-width result |
| resultValid | output | 1 | A result has been latched since reset |
| hostWord | output | 16 | Formatted host word |
| wordIdx | output | 1 | 0 = first word, 1 = second word |
| hostStbN | output | 1 | Update strobe, low for one cycle per update |
| hostStbP | output | 1 | Complement of hostStbN |

## Verification
Two functions can fall in the same cycle: a busy edge that latches a new result, and a host next-word request for the second half of the previous result. The bench provokes this by holding the next-word request high across whole conversion periods in two-word mode, so the request lands exactly on latch cycles. A behavioural model judges each such cycle. It expects the word index back at 0, the first word of the new data, and one low strobe. The same model also covers the meeting of an expired period with a still-high busy flag, which it produces by stretching the emulated conversion beyond the period.

// File: rtl/sar_capture_pkg.sv
`timescale 1ns/1ps
package sar_capture_pkg;

  typedef enum logic [1:0] {
    HM_WORD  = 2'b00,
    HM_SWAP  = 2'b01,
    HM_SPLIT = 2'b10,
    HM_RSVD  = 2'b11
  } hostMode_e;

  // strobes from the sequencer to the data path
  typedef struct packed {
    logic capture;   // latch converter data this cycle
    logic advance;   // host asks for the next word
  } capStrobes_t;

endpackage

// File: rtl/sar_capture_seq.sv
`timescale 1ns/1ps
module sar_capture_seq
  import sar_capture_pkg::*;
#(
  parameter int CONV_PERIOD = 16,
  parameter int PULSE_HIGH  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        extSel,
  input  logic        extConvStart,
  input  logic        burstMode,
  input  logic        captureRun,
  input  logic        captureSingle,
  input  logic        readDuringConv,
  input  logic        adcBusy,
  input  logic        hostNext,
  output logic        convStart,
  output capStrobes_t strobes
);

  localparam int WAIT_W = (CONV_PERIOD > 2) ? $clog2(CONV_PERIOD) : 1;
  localparam int HIGH_W = $clog2(PULSE_HIGH + 1);
  localparam logic [WAIT_W-1:0] WAIT_RELOAD = WAIT_W'(CONV_PERIOD - 1);
  localparam logic [HIGH_W-1:0] HIGH_RELOAD = HIGH_W'(PULSE_HIGH);

  logic [WAIT_W-1:0] waitCnt;
  logic [HIGH_W-1:0] highLeft;
  logic              pendSingle;
  logic              busyQ;
  logic              intPulse;
  logic              genEnable;
  logic              issue;
  logic              busyRise;
  logic              busyFall;

  assign intPulse  = (highLeft != '0);
  assign genEnable = !burstMode || captureRun || pendSingle;
  assign issue     = !extSel && genEnable && (waitCnt == '0) && !intPulse && !adcBusy;

  // pulse generator: period counter and high-time counter
  always_ff @(posedge clk) begin
    if (rst || extSel) begin
      waitCnt    <= '0;
      highLeft   <= '0;
      pendSingle <= 1'b0;
    end else begin
      if (issue) begin
        waitCnt  <= WAIT_RELOAD;
        highLeft <= HIGH_RELOAD;
      end else begin
        if (waitCnt != '0)  waitCnt  <= waitCnt - 1'b1;
        if (highLeft != '0) highLeft <= highLeft - 1'b1;
      end
      pendSingle <= captureSingle || (pendSingle && !issue);
    end
  end

  // busy edge detection
  always_ff @(posedge clk) begin
    if (rst) busyQ <= 1'b0;
    else     busyQ <= adcBusy;
  end

  assign busyRise = adcBusy && !busyQ;
  assign busyFall = !adcBusy && busyQ;

  assign convStart       = extSel ? extConvStart : intPulse;
  assign strobes.capture = readDuringConv ? busyRise : busyFall;
  assign strobes.advance = hostNext;

  // R2: a pulse only starts after a cycle with busy low
  p_no_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(intPulse) |-> $past(!adcBusy));

  // R1: the pulse is at least two cycles wide
  p_min_width_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(intPulse) |-> $past(intPulse, 2));

  // R4: in burst mode a pulse needs a run or single request
  p_burst_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(intPulse) |-> $past(!burstMode || captureRun || pendSingle));

  // R3: the internal generator stays idle under external select
  p_ext_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $past(extSel) |-> !intPulse);

endmodule

// File: rtl/sar_capture_path.sv
`timescale 1ns/1ps
module sar_capture_path
  import sar_capture_pkg::*;
#(
  parameter int RES_BITS = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  capStrobes_t         strobes,
  input  logic [1:0]          hostMode,
  input  logic [RES_BITS-1:0] adcData,
  output logic [RES_BITS-1:0] fullResult,
  output logic                resultValid,
  output logic [15:0]         hostWord,
  output logic                wordIdx,
  output logic                hostStbN,
  output logic                hostStbP
);

  localparam int EXTRA_BITS = RES_BITS - 16;

  hostMode_e   mode;
  logic [15:0] topWord;
  logic [15:0] capWord;
  logic [15:0] lowWord;
  logic        splitOk;
  logic        advanceOk;

  assign mode    = hostMode_e'(hostMode);
  assign topWord = adcData[RES_BITS-1 -: 16];

  generate
    if (EXTRA_BITS > 0) begin : g_split
      assign lowWord = {fullResult[EXTRA_BITS-1:0], {(16-EXTRA_BITS){1'b0}}};
      assign splitOk = 1'b1;
    end else begin : g_nosplit
      assign lowWord = '0;
      assign splitOk = 1'b0;
    end
  endgenerate

  always_comb begin
    case (mode)
      HM_SWAP: capWord = {topWord[7:0], topWord[15:8]};
      default: capWord = topWord;
    endcase
  end

  assign advanceOk = strobes.advance && splitOk && (mode == HM_SPLIT) &&
                     resultValid && !wordIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fullResult  <= '0;
      resultValid <= 1'b0;
      hostWord    <= '0;
      wordIdx     <= 1'b0;
      hostStbN    <= 1'b1;
    end else if (strobes.capture) begin
      fullResult  <= adcData;
      resultValid <= 1'b1;
      hostWord    <= capWord;
      wordIdx     <= 1'b0;
      hostStbN    <= 1'b0;
    end else if (advanceOk) begin
      hostWord    <= lowWord;
      wordIdx     <= 1'b1;
      hostStbN    <= 1'b0;
    end else begin
      hostStbN    <= 1'b1;
    end
  end

  assign hostStbP = !hostStbN;

  // R6: once set, valid stays set until reset
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> resultValid);

  // R8: any host word change is marked by the strobe
  p_strobe_marks_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(hostWord) |-> !hostStbN);

  // R7: a latch always returns the bus to the first word
  p_capture_first_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> !wordIdx);

  // R10: the second word only follows a valid first word in two-word mode
  p_second_word_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wordIdx) |-> $past(resultValid && hostMode == HM_SPLIT));

endmodule

// File: rtl/sar_capture_top.sv
`timescale 1ns/1ps
module sar_capture_top
  import sar_capture_pkg::*;
#(
  parameter int RES_BITS    = 18,
  parameter int CONV_PERIOD = 16,
  parameter int PULSE_HIGH  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                extSel,
  input  logic                extConvStart,
  input  logic                burstMode,
  input  logic                captureRun,
  input  logic                captureSingle,
  input  logic                readDuringConv,
  input  logic [1:0]          hostMode,
  input  logic                hostNext,
  input  logic                adcBusy,
  input  logic [RES_BITS-1:0] adcData,
  output logic                convStart,
  output logic                adcCsN,
  output logic                adcRdN,
  output logic [RES_BITS-1:0] fullResult,
  output logic                resultValid,
  output logic [15:0]         hostWord,
  output logic                wordIdx,
  output logic                hostStbN,
  output logic                hostStbP
);

  capStrobes_t strobes;

  // continuous reading: the converter bus is always driven (R5)
  assign adcCsN = 1'b0;
  assign adcRdN = 1'b0;

  sar_capture_seq #(
    .CONV_PERIOD (CONV_PERIOD),
    .PULSE_HIGH  (PULSE_HIGH)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .extSel         (extSel),
    .extConvStart   (extConvStart),
    .burstMode      (burstMode),
    .captureRun     (captureRun),
    .captureSingle  (captureSingle),
    .readDuringConv (readDuringConv),
    .adcBusy        (adcBusy),
    .hostNext       (hostNext),
    .convStart      (convStart),
    .strobes        (strobes)
  );

  sar_capture_path #(
    .RES_BITS (RES_BITS)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .hostMode    (hostMode),
    .adcData     (adcData),
    .fullResult  (fullResult),
    .resultValid (resultValid),
    .hostWord    (hostWord),
    .wordIdx     (wordIdx),
    .hostStbN    (hostStbN),
    .hostStbP    (hostStbP)
  );

endmodule

// File: tb/sar_capture_top_test.sv
`timescale 1ns/100ps
module sar_capture_top_test;

  localparam int RB = 18;
  localparam int PERIOD = 16;
  localparam int PHIGH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extSel = 1'b0, extConvStart = 1'b0, burstMode = 1'b0;
  logic captureRun = 1'b0, captureSingle = 1'b0, readDuringConv = 1'b0;
  logic [1:0] hostMode = 2'd0;
  logic hostNext = 1'b0;
  logic adcBusy = 1'b0;
  logic [RB-1:0] adcData = 18'h2A5C3;
  logic convStart, adcCsN, adcRdN, resultValid, wordIdx, hostStbN, hostStbP;
  logic [RB-1:0] fullResult;
  logic [15:0] hostWord;

  int checks = 0;
  int fails = 0;
  int convLen = 6;

  // reference model state
  int mWait = 0, mHigh = 0;
  logic mPend = 0, mBusyQ = 0, mValid = 0, mIdx = 0, mStbN = 1;
  logic [RB-1:0] mResult = '0;
  logic [15:0] mWord = '0;

  sar_capture_top #(.RES_BITS(RB), .CONV_PERIOD(PERIOD), .PULSE_HIGH(PHIGH)) uut (
    .clk(clk), .rst(rst), .extSel(extSel), .extConvStart(extConvStart),
    .burstMode(burstMode), .captureRun(captureRun), .captureSingle(captureSingle),
    .readDuringConv(readDuringConv), .hostMode(hostMode), .hostNext(hostNext),
    .adcBusy(adcBusy), .adcData(adcData), .convStart(convStart), .adcCsN(adcCsN),
    .adcRdN(adcRdN), .fullResult(fullResult), .resultValid(resultValid),
    .hostWord(hostWord), .wordIdx(wordIdx), .hostStbN(hostStbN), .hostStbP(hostStbP));

  always #2 clk = ~clk;

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    logic issue, cap, adv;
    logic [15:0] top, fmt, low;
    top = adcData[17:2];
    fmt = (hostMode == 2'd1) ? {top[7:0], top[15:8]} : top;
    low = {mResult[1:0], 14'd0};
    issue = !extSel && (!burstMode || captureRun || mPend) && mWait == 0 &&
            mHigh == 0 && !adcBusy;
    cap = readDuringConv ? (adcBusy && !mBusyQ) : (!adcBusy && mBusyQ);
    adv = hostNext && hostMode == 2'd2 && mValid && !mIdx;
    if (rst) begin
      mWait = 0; mHigh = 0; mPend = 0; mBusyQ = 0;
      mResult = '0; mValid = 0; mWord = '0; mIdx = 0; mStbN = 1;
    end else begin
      mBusyQ = adcBusy;
      if (extSel) begin
        mWait = 0; mHigh = 0; mPend = 0;
      end else begin
        if (issue) begin mWait = PERIOD - 1; mHigh = PHIGH; end
        else begin
          if (mWait > 0) mWait--;
          if (mHigh > 0) mHigh--;
        end
        mPend = captureSingle || (mPend && !issue);
      end
      mStbN = 1;
      if (cap) begin
        mResult = adcData; mValid = 1; mWord = fmt; mIdx = 0; mStbN = 0;
      end else if (adv) begin
        mWord = low; mIdx = 1; mStbN = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      chk("R1 R2 R3 R4 convStart", 32'(convStart),
          32'(extSel ? extConvStart : (mHigh != 0)));
      chk("R5 adcCsN", 32'(adcCsN), 32'd0);
      chk("R5 adcRdN", 32'(adcRdN), 32'd0);
      chk("R6 fullResult", 32'(fullResult), 32'(mResult));
      chk("R6 resultValid", 32'(resultValid), 32'(mValid));
      chk("R7 R10 hostWord", 32'(hostWord), 32'(mWord));
      chk("R7 R10 wordIdx", 32'(wordIdx), 32'(mIdx));
      chk("R8 hostStbN", 32'(hostStbN), 32'(mStbN));
      chk("R8 hostStbP", 32'(hostStbP), 32'(!mStbN));
    end
  end

  // converter emulation: busy for convLen cycles after a convert-start rise
  initial begin
    logic prevCs;
    int busyLeft;
    prevCs = 1'b0;
    busyLeft = 0;
    forever begin
      @(negedge clk);
      #1;
      if (convStart && !prevCs) busyLeft = convLen;
      prevCs = convStart;
      if (busyLeft > 0) begin
        adcBusy = 1'b1;
        busyLeft--;
      end else if (adcBusy) begin
        adcBusy = 1'b0;
        adcData = adcData * 18'd5 + 18'h1B3E7;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run(3);
    // R9: reset state
    chk("R9 reset convStart", 32'(convStart), 32'd0);
    chk("R9 reset valid", 32'(resultValid), 32'd0);
    chk("R9 reset word", 32'(hostWord), 32'd0);
    chk("R9 reset strobe", 32'(hostStbN), 32'd1);
    rst = 1'b0;
    // continuous, plain word, latch after conversion (R1, R6, R7)
    run(200);
    hostMode = 2'd1;                       // R7 byte exchange
    run(100);
    readDuringConv = 1'b1;                 // R6 latch on busy rise
    run(100);
    readDuringConv = 1'b0;
    hostMode = 2'd2;                       // R7 two-word mode
    for (int i = 0; i < 8; i++) begin
      run(5 + i);
      hostNext = 1'b1;
      @(negedge clk);
      hostNext = 1'b0;
    end
    hostNext = 1'b1;                       // R7 collision with latch, R10 repeat request
    run(80);
    hostNext = 1'b0;
    hostMode = 2'd0;                       // R10 ignored in plain mode
    hostNext = 1'b1;
    run(40);
    hostMode = 2'd3;
    run(40);
    hostNext = 1'b0;
    hostMode = 2'd2;
    convLen = PERIOD + 5;                  // R2 busy outlasts the period
    run(150);
    convLen = 6;
    run(40);
    burstMode = 1'b1;                      // R4 burst idle
    run(60);
    captureSingle = 1'b1;
    @(negedge clk);
    captureSingle = 1'b0;
    run(60);
    captureRun = 1'b1;
    run(70);
    captureRun = 1'b0;
    run(40);
    burstMode = 1'b0;
    extSel = 1'b1;                         // R3 external passthrough
    for (int i = 0; i < 6; i++) begin
      extConvStart = 1'b1;
      run(2);
      extConvStart = 1'b0;
      run(12 + i);
    end
    extSel = 1'b0;
    run(60);
    rst = 1'b1;                            // R9 reset mid-run
    run(2);
    chk("R9 mid reset valid", 32'(resultValid), 32'd0);
    chk("R9 mid reset result", 32'(fullResult), 32'd0);
    rst = 1'b0;
    run(100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule